// File: doc/BRIEF.md
# ISA Interrupt Collector Register

This block gathers eight edge-triggered interrupt request lines from an ISA-style expansion bus and presents them to a host processor as one pending word behind a small synchronous register bus. A rising edge on any request line latches a pending bit. A single summary line tells the host that at least one bit is latched. The host reads the pending word, services the sources it finds, and acknowledges each one by writing a one into that source's bit at the same address. A second, read-only address returns a fixed hardware version and issue byte.

The request lines are numbered sparsely on the expansion bus. Requests 3 through 7 and 10 through 12 exist, and 0, 1, 2, 8 and 9 have no pending bit. The block packs the eight lines that exist onto contiguous pending bits. Input `irqIn[i]` carries the request that owns pending bit `i`: bits 0..4 are requests 3..7, and bits 5, 6 and 7 are requests 10, 11 and 12. Each line is brought into the clock domain through a synchronizer before its edge is detected. After every acknowledge write the summary line is pulled low for one cycle, so that a host sensitive to rising edges sees a fresh edge whenever work remains.

Top module: `isa_irq_collector`

## Requirements
- R1: A rising edge on `irqIn[i]` (low for at least one sampled cycle, then high) sets pending bit `i`. With `SYNC_STAGES`=2 the bit is set on the third rising clock edge after the input change. It is readable from then on and `hostIrq` rises on that same edge. Bit `i` belongs to request 3+i for i<5 and to request 5+i for i>=5.
- R2: An input held high sets its bit only once. After the bit is acknowledged it stays clear until the input falls and rises again.
- R3: A write with `busWr`=1 to `PEND_ADDR` clears each pending bit whose write-data bit is 1 and leaves each bit written as 0 unchanged. A write of all zeros changes nothing.
- R4: A read of the pending word returns 0 in bits 15:8. Write-data bits 15:8 have no effect.
- R5: If a rising edge sets a bit on the same clock edge that a write clears that bit, the bit stays pending.
- R6: Except in the cycle that follows an acknowledge write, `hostIrq` is 1 exactly when the pending word is non-zero.
- R7: Every write to `PEND_ADDR` forces `hostIrq` low for the following cycle. If bits remain pending, `hostIrq` is high again one cycle later.
- R8: A read of `VER_ADDR` returns `{8'h00, HW_VERSION, HW_ISSUE}` (version in bits 7:4, issue in bits 3:0). Writes to `VER_ADDR` are ignored.
- R9: While `rst` is high at a clock edge, all pending bits, `hostIrq` and `busRdata` clear.
- R10: `busRdata` is updated on the clock edge that samples `busRd`=1 and holds its value otherwise. A read of any address other than the two defined ones returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqIn | input | 8 | Request lines, packed in pending-bit order, may be asynchronous |
| busAddr | input | 4 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| busRd | input | 1 | Read strobe |
| busRdata | output | 16 | Read data, registered |
| hostIrq | output | 1 | Summary interrupt to the host |

## Verification
The bench builds the block with its default parameters: eight sources, a 16-bit bus, a two-stage synchronizer, the pending word at address 0 and the version at address 1. With a two-stage synchronizer the edge-to-pending latency is short and known, so the bench can place an acknowledge write on exactly the clock edge where a new edge lands, and can check the set-over-clear rule and the one-cycle summary dip cycle by cycle. The version nibbles 2 and 5 give a non-symmetric pattern, so a swap of the version and issue fields shows up in the read data.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;

  // Decoded bus strobes handed from control to datapath.
  typedef struct packed {
    logic pendWr;   // acknowledge write to the pending word
    logic pendRd;   // read of the pending word
    logic verRd;    // read of the version byte
    logic otherRd;  // read of an undefined address
  } busStrobe_t;

endpackage

// File: rtl/isa_irq_sync.sv
module isa_irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int k = 1; k < STAGES; k++) begin
        stageQ[k] <= stageQ[k-1];
      end
    end
  end

  assign syncOut = stageQ[LAST];

endmodule

// File: rtl/isa_irq_ctrl.sv
module isa_irq_ctrl
  import isa_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int PEND_ADDR = 0,
  parameter int VER_ADDR  = 1
) (
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strb
);

  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_ADDR);
  localparam logic [ADDR_W-1:0] VER_A  = ADDR_W'(VER_ADDR);

  logic hitPend;
  logic hitVer;

  always_comb begin
    hitPend      = (busAddr == PEND_A);
    hitVer       = (busAddr == VER_A);
    strb.pendWr  = busWr & hitPend;
    strb.pendRd  = busRd & hitPend;
    strb.verRd   = busRd & hitVer;
    strb.otherRd = busRd & ~hitPend & ~hitVer;
  end

endmodule

// File: rtl/isa_irq_datapath.sv
module isa_irq_datapath
  import isa_irq_pkg::*;
#(
  parameter int          NUM_SRC     = 8,
  parameter int          DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  VER_VAL     = 8'h25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  busStrobe_t         strb,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               hostIrq
);

  localparam int PEND_PAD = DATA_W - NUM_SRC;
  localparam int VER_PAD  = DATA_W - 8;

  logic [NUM_SRC-1:0] syncVec;
  logic [NUM_SRC-1:0] prevVec;
  logic [NUM_SRC-1:0] riseVec;
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] pendNext;
  logic               anyRd;

  isa_irq_sync #(
    .WIDTH (NUM_SRC),
    .STAGES(SYNC_STAGES)
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(irqIn),
    .syncOut(syncVec)
  );

  // Edge detection on the synchronized lines.
  always_ff @(posedge clk) begin
    if (rst) prevVec <= '0;
    else     prevVec <= syncVec;
  end

  always_comb begin
    riseVec  = syncVec & ~prevVec;
    clrMask  = strb.pendWr ? wrData[NUM_SRC-1:0] : '0;
    // A new edge takes precedence over a simultaneous clear.
    pendNext = (pending & ~clrMask) | riseVec;
    anyRd    = strb.pendRd | strb.verRd | strb.otherRd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      hostIrq <= 1'b0;
    end else begin
      pending <= pendNext;
      // Any acknowledge write opens a one-cycle gap in the summary.
      hostIrq <= (|pendNext) & ~strb.pendWr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (anyRd) begin
      if (strb.pendRd)     rdData <= {{PEND_PAD{1'b0}}, pending};
      else if (strb.verRd) rdData <= {{VER_PAD{1'b0}}, VER_VAL};
      else                 rdData <= '0;
    end
  end

  // R1 and R5: an edge always leaves its bit set on the next cycle.
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (|riseVec) |=> ((pending & $past(riseVec)) == $past(riseVec)));

  // R3: a written one clears its bit unless an edge arrived with it.
  p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
    strb.pendWr |=> ((pending & $past(wrData[NUM_SRC-1:0]) & ~$past(riseVec)) == '0));

  // R3: without a write, no pending bit is lost.
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strb.pendWr |=> ((pending & $past(pending)) == $past(pending)));

  // R7: the summary dips after every acknowledge write.
  p_dip_r7: assert property (@(posedge clk) disable iff (rst)
    strb.pendWr |=> !hostIrq);

  // R6: outside the dip, the summary tracks the pending word.
  p_summary_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.pendWr) |-> (hostIrq == (|pending)));

  // R8: a version read returns the fixed byte.
  p_version_r8: assert property (@(posedge clk) disable iff (rst)
    strb.verRd |=> (rdData == {{VER_PAD{1'b0}}, VER_VAL}));

  // R10: read data holds when no read is strobed.
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !anyRd |=> $stable(rdData));

endmodule

// File: rtl/isa_irq_collector.sv
module isa_irq_collector
  import isa_irq_pkg::*;
#(
  parameter int         NUM_SRC     = 8,
  parameter int         ADDR_W      = 4,
  parameter int         DATA_W      = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         PEND_ADDR   = 0,
  parameter int         VER_ADDR    = 1,
  parameter logic [3:0] HW_VERSION  = 4'h2,
  parameter logic [3:0] HW_ISSUE    = 4'h5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busRd,
  output logic [DATA_W-1:0]  busRdata,
  output logic               hostIrq
);

  localparam logic [7:0] VER_VAL = {HW_VERSION, HW_ISSUE};

  busStrobe_t strb;

  isa_irq_ctrl #(
    .ADDR_W   (ADDR_W),
    .PEND_ADDR(PEND_ADDR),
    .VER_ADDR (VER_ADDR)
  ) ctrl_i (
    .busWr  (busWr),
    .busRd  (busRd),
    .busAddr(busAddr),
    .strb   (strb)
  );

  isa_irq_datapath #(
    .NUM_SRC    (NUM_SRC),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES),
    .VER_VAL    (VER_VAL)
  ) dp_i (
    .clk    (clk),
    .rst    (rst),
    .irqIn  (irqIn),
    .strb   (strb),
    .wrData (busWdata),
    .rdData (busRdata),
    .hostIrq(hostIrq)
  );

endmodule

// File: tb/isa_irq_collector_tb_top.sv
`timescale 1ns/1ps
module isa_irq_collector_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irqIn = '0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [15:0] busRdata;
  logic        hostIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdLate = 1'b0;

  localparam logic [15:0] VER_WORD = 16'h0025;

  always #5 clk = ~clk;

  isa_irq_collector #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRd(busRd), .busRdata(busRdata), .hostIrq(hostIrq)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // Driver: queue the expected word, then strobe the read.
  task automatic busRead(input logic [3:0] a, input logic [15:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Monitor: read data is valid after the edge that sampled the strobe.
  always @(posedge clk) rdLate <= busRd;

  always @(negedge clk) begin
    if (rdLate) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", busRdata);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, busRdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    chk("R9 reset hostIrq", {15'b0, hostIrq}, 16'h0);
    chk("R9 reset rdata", busRdata, 16'h0);
    rst = 1'b0;
    busRead(4'd0, 16'h0000, "R9 pending after reset");
    busRead(4'd1, VER_WORD, "R8 version");

    // R1 latency for source 0 (request 3)
    @(negedge clk); irqIn[0] = 1'b1;
    waitCyc(2);
    chk("R1 not yet pending", {15'b0, hostIrq}, 16'h0);
    waitCyc(1);
    chk("R1 hostIrq rises", {15'b0, hostIrq}, 16'h1);
    busRead(4'd0, 16'h0001, "R1 bit0 set");

    // R2 level held: ack, stays clear
    busWrite(4'd0, 16'h0001);
    waitCyc(3);
    busRead(4'd0, 16'h0000, "R2 held level no re-set");
    chk("R6 summary low when empty", {15'b0, hostIrq}, 16'h0);

    // R1 several sources (requests 5, 10, 12), bit0 stays high
    @(negedge clk); irqIn = 8'hA5;
    waitCyc(4);
    busRead(4'd0, 16'h00A4, "R1 bits 2 5 7");
    chk("R6 summary high", {15'b0, hostIrq}, 16'h1);

    // R4/R3/R7 ack bit2 with junk in upper half
    @(negedge clk); busAddr = 4'd0; busWdata = 16'hFF04; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    chk("R7 dip", {15'b0, hostIrq}, 16'h0);
    @(negedge clk);
    chk("R7 re-rise", {15'b0, hostIrq}, 16'h1);
    busRead(4'd0, 16'h00A0, "R3 R4 clear bit2 only");

    // R3 zero write changes nothing
    busWrite(4'd0, 16'h0000);
    busRead(4'd0, 16'h00A0, "R3 zero write");

    // R5 set wins: edge on bit1 lands with its clear
    @(negedge clk); irqIn = 8'h00;
    waitCyc(4);
    irqIn[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); busAddr = 4'd0; busWdata = 16'h0002; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    waitCyc(1);
    busRead(4'd0, 16'h00A2, "R5 set beats clear");

    // R6 clear all: summary stays low
    busWrite(4'd0, 16'hFFFF);
    chk("R7 dip on final ack", {15'b0, hostIrq}, 16'h0);
    waitCyc(2);
    chk("R6 low after all cleared", {15'b0, hostIrq}, 16'h0);
    busRead(4'd0, 16'h0000, "R3 all cleared");

    // R8/R10 version write ignored, unmapped read
    busWrite(4'd1, 16'h1234);
    busRead(4'd1, VER_WORD, "R8 version after write");
    busRead(4'd7, 16'h0000, "R10 unmapped read");
    waitCyc(2);
    chk("R10 rdata holds", busRdata, 16'h0000);

    // R2 re-arm: bit1 falls and rises; bit6 (request 11) rises
    @(negedge clk); irqIn[1] = 1'b0;
    waitCyc(4);
    irqIn[1] = 1'b1; irqIn[6] = 1'b1;
    waitCyc(4);
    busRead(4'd0, 16'h0042, "R2 re-armed edge");

    // R9 reset mid-run
    @(negedge clk); irqIn = 8'h00; rst = 1'b1;
    waitCyc(2);
    chk("R9 hostIrq in reset", {15'b0, hostIrq}, 16'h0);
    chk("R9 rdata in reset", busRdata, 16'h0);
    rst = 1'b0;
    waitCyc(4);
    busRead(4'd0, 16'h0000, "R9 pending after reset");

    waitCyc(3);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing reads actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule